// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 interrupt request lines and turns them into eight destination outputs: a normal interrupt line, a fast interrupt line and six auxiliary lines. Every source owns one control byte that sets three things. The first is whether the source is enabled. The second is how it triggers: active-high level, rising edge or falling edge. The third is which destination it drives. Edge events are captured in sticky status bits. Software clears these bits by writing ones to them.

For the normal and the fast output, a register returns the number of the most urgent pending source routed to that output. Software can read this register and branch straight to the right handler. Priority is fixed by default, so the lowest source number wins. Software can switch on a rotating order, in which a source that has just been reported drops to the back of the queue.

Access is through a simple synchronous word bus with per-byte write enables. Read data is registered.

Top module: `vec_intc64`

## Requirements
- R1: After reset every control byte reads 0 (disabled, level trigger, routed to destination 0), all destination outputs are low, both index registers read 63, and the status words read 0 while all inputs are low.
- R2: Bit 3 of a control byte enables its source. A disabled source never drives a destination output, but its status bit still shows its pending state.
- R3: With bits 6 and 5 both clear, the source is active-high level. Its status bit and its destination follow the input, one clock edge behind it at the output.
- R4: With bit 5 set, a 0-to-1 input transition sets the status bit. The bit stays set after the input falls. The destination output rises two edges after the input transition.
- R5: With bit 6 set, a 1-to-0 input transition sets the status bit. Leaving the input high produces no event.
- R6: The status words at 0x80 (sources 0 to 31) and 0x84 (sources 32 to 63) hold source s at bit s mod 32. Writing 1 to a bit clears a latched edge event. Writing 0 leaves the bit unchanged.
- R7: Bits [2:0] of a control byte hold a route code c. The source drives dest_o[c]: code 0 is the normal line, code 1 is the fast line, and codes 2 to 7 are auxiliary lines 0 to 5.
- R8: Bits [5:0] of the register at 0x20 (normal line) and the register at 0x24 (fast line) return the most urgent enabled, pending source routed to that line. They return 63 when none is pending. A real source 63 is confirmed by bit 31 of the word at 0x84.
- R9: In fixed order the lowest-numbered candidate wins, and reading the index does not change the order.
- R10: Bit 6 of an index register enables rotating order and reads back. Each read that reports source k in rotating order makes the next search start at k+1 and wrap around.
- R11: The control byte of source s sits at byte address 0x40+s, which is byte lane s mod 4 of the word at 0x40+4*(s/4). A write updates only the lanes whose byte enable is set. Read data appears on the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt request inputs, one per source |
| bus_en_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_be_i | input | 4 | Byte lane write enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| dest_o | output | 8 | Destination lines indexed by route code |

## Verification
A level input appears on its destination line after one clock edge. An edge input needs two: one to latch the event and one for the output register. A control write or a status clear takes effect at the edge that accepts it, so the destination line reflects it one edge later. Read data is captured at the edge that accepts the read. The bench waits exactly these edge counts on negative edges before it samples. Its read monitor pops each queued expectation on the negative edge that follows the accepting clock edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int unsigned VIC_ADDR_W = 8;
   localparam int unsigned VIC_DATA_W = 32;
   localparam int unsigned VIC_DST_W  = 3;
   localparam int unsigned VIC_N_DST  = 1 << VIC_DST_W;
   localparam int unsigned VIC_N_PRI  = 2;
   localparam int unsigned PRI_ROT_BIT = 6;

   localparam logic [VIC_ADDR_W-1:0] OFS_PRI_IRQ = 8'h20;
   localparam logic [VIC_ADDR_W-1:0] OFS_PRI_FIQ = 8'h24;
   localparam logic [VIC_ADDR_W-1:0] OFS_CTL     = 8'h40;
   localparam logic [VIC_ADDR_W-1:0] OFS_STAT    = 8'h80;

   typedef enum logic [VIC_DST_W-1:0] {
      DST_IRQ  = 3'd0,
      DST_FIQ  = 3'd1,
      DST_AUX0 = 3'd2,
      DST_AUX1 = 3'd3,
      DST_AUX2 = 3'd4,
      DST_AUX3 = 3'd5,
      DST_AUX4 = 3'd6,
      DST_AUX5 = 3'd7
   } vic_dst_e;

   typedef struct packed {
      logic     rsv7;
      logic     fall;
      logic     rise;
      logic     rsv4;
      logic     en;
      vic_dst_e dst;
   } vic_ctl_t;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic en_i,
   input  logic rise_i,
   input  logic fall_i,
   input  logic clr_i,
   output logic pend_o,
   output logic req_o
);
   logic prev_q;
   logic latch_q;
   logic edge_mode;
   logic event_s;

   assign edge_mode = rise_i | fall_i;
   assign event_s   = (rise_i & lvl_i & ~prev_q) | (fall_i & ~lvl_i & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= lvl_i;
         latch_q <= edge_mode & (event_s | (latch_q & ~clr_i));
      end
   end

   assign pend_o = edge_mode ? latch_q : lvl_i;
   assign req_o  = pend_o & en_i;
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
   parameter int unsigned N         = 64,
   parameter bit          ROTATE_EN = 1'b1,
   localparam int unsigned IW       = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic          rot_i,
   input  logic          adv_i,
   output logic [IW-1:0] idx_o,
   output logic          has_o
);
   logic [IW-1:0] hit;
   logic          found;

   if ((1 << IW) != N) begin : g_bad_n
      $error("vic_pick: N must be a power of two");
   end

   if (ROTATE_EN) begin : g_rot
      logic [IW-1:0] last_q;
      logic [IW-1:0] base;
      logic [IW-1:0] j;

      always_comb begin
         base  = rot_i ? last_q + 1'b1 : '0;
         hit   = '0;
         found = 1'b0;
         j     = '0;
         for (int k = 0; k < N; k++) begin
            j = base + IW'(k);
            if (!found && req_i[j]) begin
               hit   = j;
               found = 1'b1;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q <= '1;
         else if (adv_i && rot_i && found) last_q <= hit;
      end
   end else begin : g_fixed
      always_comb begin
         hit   = '0;
         found = |req_i;
         for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) hit = IW'(k);
         end
      end
   end

   assign idx_o = found ? hit : IW'(N - 1);
   assign has_o = found;
endmodule

// File: rtl/vec_intc64.sv
module vec_intc64
   import vic_pkg::*;
#(
   parameter int unsigned N_SRC     = 64,
   parameter bit          ROTATE_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_SRC-1:0]      src_i,
   input  logic                  bus_en_i,
   input  logic                  bus_we_i,
   input  logic [VIC_ADDR_W-1:0] bus_addr_i,
   input  logic [3:0]            bus_be_i,
   input  logic [VIC_DATA_W-1:0] bus_wdata_i,
   output logic [VIC_DATA_W-1:0] bus_rdata_o,
   output logic [VIC_N_DST-1:0]  dest_o
);
   localparam int unsigned IW     = $clog2(N_SRC);
   localparam int unsigned N_WRD  = N_SRC / VIC_DATA_W;
   localparam int unsigned CWW    = IW - 2;
   localparam int unsigned SWW    = (N_WRD > 1) ? $clog2(N_WRD) : 1;
   localparam logic [VIC_ADDR_W:0] CTL_LO  = {1'b0, OFS_CTL};
   localparam logic [VIC_ADDR_W:0] CTL_HI  = CTL_LO + (VIC_ADDR_W+1)'(N_SRC);
   localparam logic [VIC_ADDR_W:0] STAT_LO = {1'b0, OFS_STAT};
   localparam logic [VIC_ADDR_W:0] STAT_HI = STAT_LO + (VIC_ADDR_W+1)'(4 * N_WRD);

   if (N_SRC != 32 && N_SRC != 64) begin : g_bad_cfg
      $error("vec_intc64: N_SRC must be 32 or 64");
   end

   // bus decode
   logic                  wr_s, rd_s, aligned;
   logic [VIC_ADDR_W:0]   addr9;
   logic                  hit_ctl, hit_stat;
   logic [VIC_N_PRI-1:0]  hit_pri;
   logic [CWW-1:0]        ctl_word;
   logic [SWW-1:0]        stat_word;

   assign aligned   = (bus_addr_i[1:0] == 2'b00);
   assign wr_s      = bus_en_i & bus_we_i & aligned;
   assign rd_s      = bus_en_i & ~bus_we_i & aligned;
   assign addr9     = {1'b0, bus_addr_i};
   assign hit_ctl   = (addr9 >= CTL_LO) && (addr9 < CTL_HI);
   assign hit_stat  = (addr9 >= STAT_LO) && (addr9 < STAT_HI);
   assign hit_pri[0] = (bus_addr_i == OFS_PRI_IRQ);
   assign hit_pri[1] = (bus_addr_i == OFS_PRI_FIQ);
   assign ctl_word  = bus_addr_i[2 +: CWW];
   assign stat_word = (N_WRD > 1) ? bus_addr_i[2 +: SWW] : '0;

   // per-source control and pending state
   logic [8*N_SRC-1:0]                  ctl_flat;
   logic [N_SRC-1:0]                    pend_v;
   logic [N_SRC-1:0]                    req_v;
   logic [N_SRC-1:0]                    clr_v;
   logic [VIC_N_DST-1:0][N_SRC-1:0]     dreq;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      localparam int unsigned CW = s / 4;
      localparam int unsigned CB = s % 4;
      localparam int unsigned SW = s / VIC_DATA_W;
      localparam int unsigned SB = s % VIC_DATA_W;
      vic_ctl_t ctl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ctl_q <= '0;
         else if (wr_s && hit_ctl && ctl_word == CWW'(CW) && bus_be_i[CB])
            ctl_q <= vic_ctl_t'(bus_wdata_i[8*CB +: 8]);
      end

      assign ctl_flat[8*s +: 8] = ctl_q;
      assign clr_v[s] = wr_s && hit_stat && stat_word == SWW'(SW) &&
                        bus_be_i[SB/8] && bus_wdata_i[SB];

      vic_src_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl_i  (src_i[s]),
         .en_i   (ctl_q.en),
         .rise_i (ctl_q.rise),
         .fall_i (ctl_q.fall),
         .clr_i  (clr_v[s]),
         .pend_o (pend_v[s]),
         .req_o  (req_v[s])
      );

      for (genvar d = 0; d < VIC_N_DST; d++) begin : g_route
         assign dreq[d][s] = req_v[s] && (ctl_q.dst == vic_dst_e'(d));
      end
   end

   // destination outputs
   logic [VIC_N_DST-1:0] dest_n;
   for (genvar d = 0; d < VIC_N_DST; d++) begin : g_dest
      assign dest_n[d] = |dreq[d];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dest_o <= '0;
      else        dest_o <= dest_n;
   end

   // vector index registers for the normal and fast lines
   logic [VIC_N_PRI-1:0]          rot_q;
   logic [VIC_N_PRI-1:0][IW-1:0]  pidx;
   logic [VIC_N_PRI-1:0]          phas;

   for (genvar p = 0; p < VIC_N_PRI; p++) begin : g_pri
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rot_q[p] <= 1'b0;
         else if (wr_s && hit_pri[p] && bus_be_i[0])
            rot_q[p] <= ROTATE_EN & bus_wdata_i[PRI_ROT_BIT];
      end

      vic_pick #(
         .N         (N_SRC),
         .ROTATE_EN (ROTATE_EN)
      ) u_pick (
         .clk   (clk),
         .rst_n (rst_n),
         .req_i (dreq[p]),
         .rot_i (rot_q[p]),
         .adv_i (rd_s && hit_pri[p]),
         .idx_o (pidx[p]),
         .has_o (phas[p])
      );
   end

   // read path
   logic [VIC_DATA_W-1:0] rdata_n;
   always_comb begin
      rdata_n = '0;
      if (hit_pri[0]) begin
         rdata_n[IW-1:0]        = pidx[0];
         rdata_n[PRI_ROT_BIT]   = rot_q[0];
      end else if (hit_pri[1]) begin
         rdata_n[IW-1:0]        = pidx[1];
         rdata_n[PRI_ROT_BIT]   = rot_q[1];
      end else if (hit_ctl) begin
         rdata_n = ctl_flat[VIC_DATA_W*ctl_word +: VIC_DATA_W];
      end else if (hit_stat) begin
         rdata_n = pend_v[VIC_DATA_W*stat_word +: VIC_DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bus_rdata_o <= '0;
      else if (rd_s) bus_rdata_o <= rdata_n;
   end

   // signals observed by the bound checker
   logic [N_SRC-1:0] irq_req;
   logic [IW-1:0]    irq_idx;
   logic             irq_has;
   logic             irq_rot;
   assign irq_req = dreq[0];
   assign irq_idx = pidx[0];
   assign irq_has = phas[0];
   assign irq_rot = rot_q[0];
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int unsigned N_SRC = 64,
   localparam int unsigned IW   = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             src0,
   input logic             bus_en_i,
   input logic             bus_we_i,
   input logic [7:0]       bus_addr_i,
   input logic             be0,
   input logic             wd0,
   input logic             dest_irq,
   input logic [N_SRC-1:0] irq_req,
   input logic [IW-1:0]    irq_idx,
   input logic             irq_has,
   input logic             irq_rot,
   input logic [7:0]       ctl0,
   input logic             pend0
);
   logic [N_SRC-1:0] low_mask;
   logic             rd_pri;
   logic             clr0;

   always_comb begin
      for (int k = 0; k < N_SRC; k++) low_mask[k] = (IW'(k) < irq_idx);
   end

   assign rd_pri = bus_en_i && !bus_we_i && bus_addr_i == 8'h20;
   assign clr0   = bus_en_i && bus_we_i && bus_addr_i == 8'h80 && be0 && wd0;

   AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_has |-> irq_req[irq_idx]); // R8

   AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req == '0) |-> (irq_idx == IW'(N_SRC - 1) && !irq_has)); // R8

   AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_rot && irq_has) |-> ((irq_req & low_mask) == '0)); // R9

   AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr0 && ctl0[5] && !ctl0[6] && !src0) |=> !pend0); // R6

   AST_DEST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      dest_irq |-> $past(|irq_req)); // R2

   AST_ROT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_pri) && $past(irq_has) && $past(irq_rot) && irq_rot &&
       irq_req == $past(irq_req) && $countones(irq_req) > 1)
      |-> irq_idx != $past(irq_idx)); // R10
endmodule

bind vec_intc64 vic_chk #(.N_SRC(N_SRC)) u_vic_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src0       (src_i[0]),
   .bus_en_i   (bus_en_i),
   .bus_we_i   (bus_we_i),
   .bus_addr_i (bus_addr_i),
   .be0        (bus_be_i[0]),
   .wd0        (bus_wdata_i[0]),
   .dest_irq   (dest_o[0]),
   .irq_req    (irq_req),
   .irq_idx    (irq_idx),
   .irq_has    (irq_has),
   .irq_rot    (irq_rot),
   .ctl0       (ctl_flat[7:0]),
   .pend0      (pend_v[0])
);

// File: tb/vec_intc64_bench.sv
module vec_intc64_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] src;
   logic        en, we;
   logic [7:0]  addr;
   logic [3:0]  be;
   logic [31:0] wd;
   logic [31:0] rdata;
   logic [7:0]  dest;

   always #2 clk = ~clk;

   vec_intc64 u_vec_intc64 (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src),
      .bus_en_i    (en),
      .bus_we_i    (we),
      .bus_addr_i  (addr),
      .bus_be_i    (be),
      .bus_wdata_i (wd),
      .bus_rdata_o (rdata),
      .dest_o      (dest)
   );

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;
   logic [31:0] e_cur;
   string       t_cur;

   // monitor: pops one expectation per accepted read
   always @(posedge clk) rd_seen <= en & ~we;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: read with no expectation, act=%h exp=none", rdata);
         end else begin
            e_cur = exp_q.pop_front();
            t_cur = tag_q.pop_front();
            checks++;
            if (rdata !== e_cur) begin
               errors++;
               $display("FAIL %s: rdata act=%h exp=%h", t_cur, rdata, e_cur);
            end
         end
      end
   end

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", t, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      en = 1'b1; we = 1'b1; addr = a; be = b; wd = d;
      @(negedge clk);
      en = 1'b0; we = 1'b0; be = 4'h0;
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string t);
      @(negedge clk);
      en = 1'b1; we = 1'b0; addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(t);
      @(negedge clk);
      en = 1'b0;
   endtask

   task automatic set_src(input int i, input logic v);
      @(negedge clk);
      src[i] = v;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; en = 1'b0; we = 1'b0; addr = '0; be = '0; wd = '0; src = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle(1);

      // R1 reset state
      chk("R1 dest after reset", {24'h0, dest}, 32'h0);
      bus_rd(8'h40, 32'h0, "R1 ctl word 0x40");
      bus_rd(8'h7C, 32'h0, "R1 ctl word 0x7C");
      bus_rd(8'h20, 32'd63, "R1 irq index idle");
      bus_rd(8'h24, 32'd63, "R1 fiq index idle");
      bus_rd(8'h80, 32'h0, "R1 status word 0");

      // R2 disabled source, R3 level behaviour
      set_src(4, 1'b1);
      settle(2);
      chk("R2 disabled source no dest", {24'h0, dest}, 32'h0);
      bus_rd(8'h80, 32'h0000_0010, "R3 level status while disabled");
      bus_wr(8'h44, 4'b0001, 32'h0000_0008);
      settle(1);
      chk("R2 enabled level dest", {24'h0, dest}, 32'h1);
      bus_rd(8'h20, 32'd4, "R8 index reports 4");
      set_src(4, 1'b0);
      settle(1);
      chk("R3 level drop clears dest", {24'h0, dest}, 32'h0);
      bus_rd(8'h20, 32'd63, "R8 index idle again");

      // R11 byte lane write
      bus_wr(8'h44, 4'b0010, 32'hFFFF_09FF);
      bus_rd(8'h44, 32'h0000_0908, "R11 lane write only");

      // R7 routing
      set_src(5, 1'b1);
      settle(1);
      chk("R7 route code 1 fast line", {24'h0, dest}, 32'h02);
      bus_rd(8'h24, 32'd5, "R8 fiq index 5");
      bus_rd(8'h20, 32'd63, "R7 irq index unaffected");
      bus_wr(8'h44, 4'b0010, 32'h0000_0F00);
      settle(1);
      chk("R7 route code 7 aux line 5", {24'h0, dest}, 32'h80);
      set_src(5, 1'b0);
      settle(1);
      chk("R7 aux line drops", {24'h0, dest}, 32'h0);

      // R4 rising edge
      bus_wr(8'h48, 4'b0001, 32'h0000_0028);
      set_src(8, 1'b1);
      settle(1);
      chk("R4 one edge after rise", {24'h0, dest}, 32'h0);
      settle(1);
      chk("R4 two edges after rise", {24'h0, dest}, 32'h1);
      set_src(8, 1'b0);
      settle(2);
      chk("R4 latched after input falls", {24'h0, dest}, 32'h1);
      bus_rd(8'h80, 32'h0000_0100, "R4 status latched");

      // R6 write one to clear
      bus_wr(8'h80, 4'b1111, 32'hFFFF_FEFF);
      bus_rd(8'h80, 32'h0000_0100, "R6 zero bits keep status");
      bus_wr(8'h80, 4'b1111, 32'h0000_0100);
      bus_rd(8'h80, 32'h0, "R6 one bit clears status");
      chk("R6 dest drops after clear", {24'h0, dest}, 32'h0);

      // R5 falling edge
      set_src(9, 1'b1);
      settle(2);
      bus_wr(8'h48, 4'b0010, 32'h0000_4800);
      bus_rd(8'h80, 32'h0, "R5 high input no event");
      set_src(9, 1'b0);
      settle(2);
      chk("R5 falling edge dest", {24'h0, dest}, 32'h1);
      bus_rd(8'h80, 32'h0000_0200, "R5 falling status");
      bus_wr(8'h80, 4'b0010, 32'h0000_0200);
      bus_rd(8'h80, 32'h0, "R6 clear falling event");

      // R8 source 63 versus idle
      bus_wr(8'h7C, 4'b1000, 32'h0800_0000);
      set_src(63, 1'b1);
      settle(1);
      chk("R8 source 63 dest", {24'h0, dest}, 32'h1);
      bus_rd(8'h20, 32'd63, "R8 index 63 real");
      bus_rd(8'h84, 32'h8000_0000, "R8 confirm bit 31");
      set_src(63, 1'b0);
      bus_rd(8'h84, 32'h0, "R8 bit 31 clear when idle");
      bus_rd(8'h20, 32'd63, "R8 idle index");

      // R9 fixed order
      bus_wr(8'h40, 4'b0100, 32'h0008_0000);
      bus_wr(8'h44, 4'b0010, 32'h0000_0800);
      bus_wr(8'h48, 4'b0010, 32'h0000_0800);
      set_src(2, 1'b1);
      set_src(5, 1'b1);
      set_src(9, 1'b1);
      settle(1);
      bus_rd(8'h20, 32'd2, "R9 lowest wins");
      bus_rd(8'h20, 32'd2, "R9 read keeps order");
      bus_rd(8'h24, 32'd63, "R9 fiq has none");

      // R10 rotating order
      bus_wr(8'h20, 4'b0001, 32'h0000_0040);
      bus_rd(8'h20, 32'h42, "R10 first rotating pick");
      bus_rd(8'h20, 32'h45, "R10 second rotating pick");
      bus_rd(8'h20, 32'h49, "R10 third rotating pick");
      bus_rd(8'h20, 32'h42, "R10 wraps around");
      set_src(2, 1'b0);
      settle(1);
      bus_rd(8'h20, 32'h45, "R10 next after last report");
      bus_wr(8'h20, 4'b0001, 32'h0);
      bus_rd(8'h20, 32'h05, "R9 fixed again");

      settle(3);
      chk("R11 all reads answered", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: act=timeout exp=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule